// File: doc/BRIEF.md
# Switchable Byte Comparator Array

This block is the leaf layer of a hardware text search engine. It holds a row of byte comparators fed by a binary tree of 2:1 selectors. A byte stream enters at the root of the tree. Each internal node of the tree chooses what its right subtree sees. It either passes on its own input, so the subtree sees the same byte as the left subtree (broadcast), or it passes the byte held by the last comparator of its left subtree, so the row continues as a shift chain. One array can therefore hold a single long pattern laid out along one chain, or several short patterns side by side that all watch the same stream position.

Each comparator keeps the byte it last took in. It tests that byte against a reference byte that is loaded beforehand, using one of four unsigned relations. It drives a result bit and an equality bit. A higher result tree (not part of this block) can combine these bits into pattern hits and ordered comparisons. Set-up goes through a small write port. The port is locked while a search is running.

Top module: `cmp_dist_array`

## Requirements
- R1: While `rst` is high on a clock edge, every held byte becomes 0x00, every reference becomes 0x00, every operator code becomes 0, every enable becomes 0 and every node mode bit becomes 0 (serial). `hit` and `eq` then read all zeros.
- R2: On an edge where `in_valid` is low, no held byte changes, so `hit` and `eq` stay as they were.
- R3: Mode bit 0 on a node selects serial delivery. On each valid edge, the leftmost comparator of that node's right subtree, and the chain below it, takes the byte that the rightmost comparator of the left subtree held before the edge. Comparator 0 always takes `in_byte`.
- R4: Mode bit 1 on a node selects broadcast delivery. Its right subtree takes the same byte as the node's own input. With all nodes set to broadcast, every comparator takes `in_byte`.
- R5: Operator codes compare the held byte H with the reference byte F, both unsigned. Code 0 gives H==F, code 1 gives H!=F, code 2 gives H<F and code 3 gives H>=F. Outputs are combinational from the held state and the configuration, so they are visible in the cycle after the edge.
- R6: A comparator whose enable is 0 drives 0 on both its `hit` bit and its `eq` bit, whatever its bytes are.
- R7: An enabled comparator drives `eq` = (H==F) whatever its operator code is.
- R8: Operator code 3 with reference 0x00 is a wildcard that hits on every byte value, including 0x00 and 0xFF.
- R9: While `search_active` is high, writes on the configuration port are ignored. No reference, operator, enable or mode bit changes.
- R10: The configuration map is as follows. Address i < NPE loads comparator i: bits [7:0] are the reference, [9:8] the operator code and [10] the enable. Address NPE loads the mode bits: bit k belongs to tree node k+1. Nodes are numbered from 1 at the root, and node n has children 2n (left, lower comparator indices) and 2n+1. Any other address is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| search_active | input | 1 | High while a search runs; locks configuration |
| in_valid | input | 1 | Advances all comparators by one byte |
| in_byte | input | 8 | Stream byte at the tree root |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 5 | Configuration address |
| cfg_data | input | 15 | Configuration write data |
| hit | output | 16 | Per-comparator result bit |
| eq | output | 16 | Per-comparator equality bit |

## Verification
The embedded properties check several behaviours on every cycle. Comparator 0 always loads the stream byte. The root's right half either shifts from its left half or copies the stream, as its mode bit says. Held bytes freeze when the strobe is low, and a locked write leaves every configuration field unchanged. They also tie each output bit's value to its enable and to the operator code. Only the bench scenarios can show that bytes move through whole chains in the right positions over many cycles under serial, broadcast and mixed tree settings. The scenarios also cover the full operator truth at boundary values and the wildcard. Finally, they show that writes to unused addresses leave all state unchanged.

// File: rtl/cmp_dist_array.sv
module cmp_dist_array #(
  parameter int NPE = 16,
  parameter int W   = 8,
  localparam int NODES = NPE - 1,
  localparam int AW    = $clog2(NPE + 1),
  localparam int CFG_W = (NPE - 1 > W + 3) ? NPE - 1 : W + 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             search_active,
  input  logic             in_valid,
  input  logic [W-1:0]     in_byte,
  input  logic             cfg_we,
  input  logic [AW-1:0]    cfg_addr,
  input  logic [CFG_W-1:0] cfg_data,
  output logic [NPE-1:0]   hit,
  output logic [NPE-1:0]   eq
);

  logic [W-1:0]     held   [NPE];
  logic [W-1:0]     ref_q  [NPE];
  logic [1:0]       op_q   [NPE];
  logic [NPE-1:0]   en_q;
  logic [NODES-1:0] mode_q;
  logic [W-1:0]     node_d [1:2*NPE-1];

  wire cfg_ok = cfg_we && !search_active;

  function automatic int last_of_left(input int n);
    int d;
    int span;
    d = 0;
    for (int k = 0; k < 31; k++)
      if ((n >> (k + 1)) != 0) d = k + 1;
    span = NPE >> d;
    return (n - (1 << d)) * span + span / 2 - 1;
  endfunction

  always_comb begin
    node_d[1] = in_byte;
    for (int n = 1; n < NPE; n++) begin
      node_d[2*n]   = node_d[n];
      node_d[2*n+1] = mode_q[n-1] ? node_d[n] : held[last_of_left(n)];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NPE; i++) held[i] <= '0;
    end else if (in_valid) begin
      for (int i = 0; i < NPE; i++) held[i] <= node_d[NPE+i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NPE; i++) begin
        ref_q[i] <= '0;
        op_q[i]  <= 2'd0;
      end
      en_q   <= '0;
      mode_q <= '0;
    end else if (cfg_ok) begin
      for (int i = 0; i < NPE; i++) begin
        if (cfg_addr == AW'(i)) begin
          ref_q[i] <= cfg_data[W-1:0];
          op_q[i]  <= cfg_data[W+1:W];
          en_q[i]  <= cfg_data[W+2];
        end
      end
      if (cfg_addr == AW'(NPE)) mode_q <= cfg_data[NODES-1:0];
    end
  end

  for (genvar i = 0; i < NPE; i++) begin : g_pe
    logic rel;
    always_comb begin
      case (op_q[i])
        2'd0:    rel = held[i] == ref_q[i];
        2'd1:    rel = held[i] != ref_q[i];
        2'd2:    rel = held[i] <  ref_q[i];
        default: rel = held[i] >= ref_q[i];
      endcase
    end
    assign hit[i] = en_q[i] & rel;
    assign eq[i]  = en_q[i] & (held[i] == ref_q[i]);

    assert_quiet_when_off_R6: assert property (@(posedge clk) disable iff (rst)
      (hit[i] || eq[i]) |-> en_q[i]);
    assert_eq_agrees_R7: assert property (@(posedge clk) disable iff (rst)
      eq[i] |-> (hit[i] == (op_q[i] == 2'd0 || op_q[i] == 2'd3)));
  end

  assert_root_feed_R3: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> held[0] == $past(in_byte));
  assert_serial_shift_R3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !mode_q[0]) |=> held[NPE/2] == $past(held[NPE/2-1]));
  assert_broadcast_R4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode_q[0]) |=> held[NPE/2] == $past(in_byte));
  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (held[0] == $past(held[0]) && held[NPE-1] == $past(held[NPE-1])));
  assert_cfg_locked_R9: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && search_active) |=> ($stable(mode_q) && $stable(en_q) &&
                                   ref_q[0] == $past(ref_q[0]) && op_q[0] == $past(op_q[0])));

endmodule

// File: tb/cmp_dist_array_test.sv
module cmp_dist_array_test;
  localparam int NPE = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        search_active = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_byte = 8'h00;
  logic        cfg_we = 1'b0;
  logic [4:0]  cfg_addr = 5'd0;
  logic [14:0] cfg_data = 15'd0;
  logic [15:0] hit, eq;

  cmp_dist_array uut (
    .clk(clk), .rst(rst), .search_active(search_active), .in_valid(in_valid),
    .in_byte(in_byte), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
    .hit(hit), .eq(eq)
  );

  always #2 clk = ~clk;

  localparam logic [7:0] STIM [0:23] = '{
    8'h41, 8'h42, 8'h43, 8'h44, 8'h40, 8'h45, 8'h41, 8'h41,
    8'h42, 8'h00, 8'hFF, 8'h44, 8'h43, 8'h42, 8'h41, 8'h44,
    8'h41, 8'h42, 8'h43, 8'h44, 8'h7F, 8'h80, 8'h41, 8'h43
  };
  localparam logic [14:0] MODES [0:2] = '{15'h0000, 15'h7FFF, 15'h0025};

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  logic [7:0]  m_held [NPE];
  logic [7:0]  m_ref  [NPE];
  logic [1:0]  m_op   [NPE];
  logic        m_en   [NPE];
  logic [14:0] m_mode;

  function automatic int src_of(input int i);
    int s, n, span, first, half;
    s = -1; n = 1; span = NPE; first = 0;
    while (span > 1) begin
      half = span / 2;
      if (i >= first + half) begin
        if (!m_mode[n-1]) s = first + half - 1;
        n = 2 * n + 1;
        first = first + half;
      end else begin
        n = 2 * n;
      end
      span = half;
    end
    return s;
  endfunction

  function automatic logic [31:0] expect_out();
    logic [15:0] h, e;
    for (int i = 0; i < NPE; i++) begin
      logic r;
      case (m_op[i])
        2'd0: r = m_held[i] == m_ref[i];
        2'd1: r = m_held[i] != m_ref[i];
        2'd2: r = m_held[i] <  m_ref[i];
        default: r = m_held[i] >= m_ref[i];
      endcase
      h[i] = m_en[i] & r;
      e[i] = m_en[i] & (m_held[i] == m_ref[i]);
    end
    return {h, e};
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic step(input logic v, input logic [7:0] b);
    logic [7:0] old [NPE];
    @(negedge clk);
    in_valid = v; in_byte = b;
    @(posedge clk);
    if (v) begin
      for (int i = 0; i < NPE; i++) old[i] = m_held[i];
      for (int i = 0; i < NPE; i++) begin
        int s;
        s = src_of(i);
        m_held[i] = (s < 0) ? b : old[s];
      end
    end
    #1 in_valid = 1'b0;
  endtask

  task automatic wr(input logic [4:0] a, input logic [14:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_data = d;
    @(posedge clk);
    if (!search_active) begin
      if (a < NPE) begin
        m_ref[a] = d[7:0]; m_op[a] = d[9:8]; m_en[a] = d[10];
      end else if (a == NPE) begin
        m_mode = d;
      end
    end
    #1 cfg_we = 1'b0;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    for (int i = 0; i < NPE; i++) begin
      m_held[i] = 8'h00; m_ref[i] = 8'h00; m_op[i] = 2'd0; m_en[i] = 1'b0;
    end
    m_mode = 15'h0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 outputs after reset", {hit, eq}, 32'h0);
    @(negedge clk) rst = 1'b0;

    // R1 held bytes are zero; R10 field layout
    wr(5'd0, 15'h0400);
    chk("R1 R10 held zero matches ref 00", {hit, eq}, 32'h0001_0001);

    for (int i = 0; i < NPE; i++)
      wr(5'(i), 15'({(i != 5), 2'(i / 4), 8'(8'h41 + (i % 4))}));
    chk("R6 R10 configured state", {hit, eq}, expect_out());

    for (int p = 0; p < 3; p++) begin
      wr(5'd16, MODES[p]);
      for (int v = 0; v < 24; v++) begin
        step(1'b1, STIM[v]);
        chk(p == 0 ? "R3 R5 R7 serial" : (p == 1 ? "R4 R5 R7 broadcast" : "R3 R4 R5 mixed"),
            {hit, eq}, expect_out());
      end
    end

    // R2 strobe low holds state
    step(1'b0, 8'h41);
    chk("R2 valid low", {hit, eq}, expect_out());
    step(1'b0, 8'h00);
    chk("R2 valid low again", {hit, eq}, expect_out());

    // R9 writes locked while searching
    @(negedge clk) search_active = 1'b1;
    wr(5'd0, 15'h0799);
    wr(5'd16, 15'h0000);
    wr(5'd5, 15'h0441);
    chk("R9 locked writes", {hit, eq}, expect_out());
    step(1'b1, 8'h43);
    chk("R9 mode unchanged while locked", {hit, eq}, expect_out());
    @(negedge clk) search_active = 1'b0;

    // R10 unused addresses ignored
    wr(5'd20, 15'h7FFF);
    wr(5'd31, 15'h0000);
    step(1'b1, 8'h42);
    chk("R10 unused address", {hit, eq}, expect_out());

    // R8 wildcard under broadcast
    wr(5'd16, 15'h7FFF);
    wr(5'd3, 15'h0700);
    step(1'b1, 8'h00);
    chk("R8 wildcard 00", {31'h0, hit[3]}, 32'h1);
    step(1'b1, 8'hFF);
    chk("R8 wildcard FF", {31'h0, hit[3]}, 32'h1);
    chk("R8 full state", {hit, eq}, expect_out());

    // R6 disabled comparator with matching byte
    wr(5'd6, 15'h00FF);
    chk("R6 disabled stays quiet", {30'h0, hit[6], eq[6]}, 32'h0);
    wr(5'd6, 15'h04FF);
    chk("R7 re-enabled equal", {30'h0, hit[6], eq[6]}, 32'h3);

    // R5 boundaries of lt and ge
    wr(5'd8, 15'h0680);
    wr(5'd12, 15'h0780);
    step(1'b1, 8'h7F);
    chk("R5 lt/ge below", {30'h0, hit[8], hit[12]}, 32'h2);
    step(1'b1, 8'h80);
    chk("R5 lt/ge equal", {30'h0, hit[8], hit[12]}, 32'h1);

    summary();
  end
endmodule